// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds the page table entry that maps a 32-bit effective address, given as a segment ID and a page index, in a hashed page table in memory. From the segment ID and page index it forms a hash and picks a group of eight eight-byte entries. It scans that group one entry after another and stops at the first match. If the first group has no match, it searches a second group selected by the complemented hash.

On a hit the block works out read, write and execute rights from a key bit, the entry's two-bit protection code and a no-execute flag. It then judges the requested access against those rights. Finally it sets the entry's referenced and changed flags, writing the entry's second word back only when one of them actually changes.

A requester raises a one-cycle request while the walker is idle. It then waits for the one-cycle `done` pulse, which comes with a status, a physical page number and the granted rights. All table traffic uses a single word port with a valid/ready handshake.

Top module: `hpt_walker`

## Requirements
- R1: The first memory read of a walk is at address `base + ((H << 6) & mask)`, where H is the 32-bit value `vsid ^ pidx` with both zero-extended.
- R2: Entries are read as a 32-bit upper word at group + 8*slot, for slots 0 to 7 in order. Upper word layout: bit 31 valid, bits 30:7 segment ID, bit 6 hash-select, bits 5:0 page index bits 15:10. An entry matches when it is valid, its hash-select bit equals the pass (0 primary, 1 secondary) and both ID fields are equal. The scan stops at the first match and reads only that entry's lower word, at +4.
- R3: With no match in the primary group, the walker scans the group at `base + ((~H << 6) & mask)`. With no match there either, it reports status 1 (miss) with rights 000 and writes nothing.
- R4: With key 0, protection codes 0, 1 and 2 give read and write, and code 3 gives read only. The protection code is lower-word bits 1:0. Rights are reported as {read, write, execute}.
- R5: With key 1, code 0 gives no read or write, codes 1 and 3 give read only, and code 2 gives read and write.
- R6: Execute is granted only when the no-execute flag is 0. Access codes: 0 load (needs read), 1 store (needs write), 2 fetch (needs execute), 3 treated as load. A hit reports status 0 if the access is allowed and status 2 otherwise.
- R7: Every hit sets the referenced flag (lower-word bit 8). The changed flag (bit 7) is set only by an allowed store. When the changed flag stays clear, write is removed from the reported rights.
- R8: The lower word is written back, once and at the entry address + 4, only when the referenced or changed flag changes value. Other bits are kept.
- R9: `mem_valid` stays high with `mem_addr` and `mem_write` unchanged until `mem_ready` is seen.
- R10: `done` is a one-cycle pulse that comes with `busy` low. Requests arriving while busy are ignored. On a hit, `rpn` equals lower-word bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vsid | input | 24 | Segment ID |
| req_pidx | input | 16 | Page index within the segment |
| req_key | input | 1 | Protection key |
| req_nx | input | 1 | Segment no-execute flag |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 32 | Mask applied to the shifted hash |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 hit allowed, 1 miss, 2 hit denied |
| rpn | output | 20 | Physical page number |
| rights | output | 3 | Granted {read, write, execute} |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or returns data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |

## Verification
The bench keeps the default widths and uses a table of 128 groups (mask 0x1FC0) at base 0x2000. This fits a 16 KB word model, so both hash groups always land in different places.

It sweeps every combination of key, protection code, no-execute flag, access type and starting referenced/changed state: 192 walks. Each walk places the entry in a rotating slot, alternating between the primary and secondary group. That covers every protection outcome, every write-back decision and every scan depth.

A pseudo-random `mem_ready` pattern stretches each handshake. Directed walks add a full miss with decoys, first-match ordering and a request issued mid-walk.

// File: rtl/hpt_pkg.sv
// Shared types and entry field positions for the hashed page table walker.
// Assumes 32-bit table words with an 8-byte entry (upper word, lower word).
package hpt_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_HIT  = 2'd0,
        ST_MISS = 2'd1,
        ST_DENY = 2'd2
    } stat_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_HI,
        S_RD_LO,
        S_WRBACK
    } walk_e;

    // Upper word fields
    localparam int HI_VALID = 31;
    localparam int HI_HSEL  = 6;
    // Lower word fields
    localparam int LO_REF   = 8;
    localparam int LO_CHG   = 7;

endpackage

// File: rtl/hpt_group_addr.sv
// Computes the byte address of a hash group.
// Assumes: hash = segment ID XOR page index; the secondary pass uses its
// bitwise complement; the shifted hash is masked before the base is added.
module hpt_group_addr #(
    parameter int ADDR_W    = 32,
    parameter int VSID_W    = 24,
    parameter int PIDX_W    = 16,
    parameter int GRP_SHIFT = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              second,
    output logic [ADDR_W-1:0] grp_addr
);
    logic [ADDR_W-1:0] hash_raw;
    logic [ADDR_W-1:0] hash_sel;

    // Forms the pass-dependent hash and the masked group address.
    always_comb begin
        hash_raw = ADDR_W'(vsid) ^ ADDR_W'(pidx);
        hash_sel = second ? ~hash_raw : hash_raw;
        grp_addr = base + ((hash_sel << GRP_SHIFT) & mask);
    end
endmodule

// File: rtl/hpt_access_check.sv
// Protection decode and flag update for a matched entry.
// Assumes: rights are {read, write, execute}; key selects between the two
// protection tables; the caller writes back only when need_wb is set.
module hpt_access_check
    import hpt_pkg::*;
(
    input  logic       key,
    input  logic       nx,
    input  logic [1:0] acc,
    input  logic [1:0] pp,
    input  logic       ref_in,
    input  logic       chg_in,
    output logic [2:0] rights,
    output logic       allow,
    output logic       chg_out,
    output logic       need_wb
);
    logic rd_ok, wr_ok, ex_ok, store_ok;

    // Decodes base rights from key and protection code.
    always_comb begin
        if (!key) begin
            rd_ok = 1'b1;
            wr_ok = (pp != 2'd3);
        end else begin
            rd_ok = (pp != 2'd0);
            wr_ok = (pp == 2'd2);
        end
        ex_ok = !nx;
    end

    // Judges the access and derives flag updates and reported rights.
    always_comb begin
        case (acc)
            ACC_STORE: allow = wr_ok;
            ACC_FETCH: allow = ex_ok;
            default:   allow = rd_ok;
        endcase
        store_ok = (acc == ACC_STORE) && allow;
        chg_out  = chg_in | store_ok;
        rights   = {rd_ok, wr_ok & chg_out, ex_ok};
        need_wb  = !ref_in || (chg_out && !chg_in);
    end
endmodule

// File: rtl/hpt_walker.sv
// Sequential hashed page table walker.
// Scans the primary group, then the secondary group, one upper word per
// memory transaction; on a hit reads the lower word, checks protection and
// lazily writes back the referenced/changed flags. Assumes a memory port
// whose read data is valid in the cycle mem_ready is high.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int VSID_W  = 24,
    parameter int PIDX_W  = 16,
    parameter int GROUP_N = 8,
    parameter int PG_SHIFT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [VSID_W-1:0]       req_vsid,
    input  logic [PIDX_W-1:0]       req_pidx,
    input  logic                    req_key,
    input  logic                    req_nx,
    input  logic [1:0]              req_acc,
    input  logic [ADDR_W-1:0]       tbl_base,
    input  logic [ADDR_W-1:0]       tbl_mask,
    output logic                    busy,
    output logic                    done,
    output logic [1:0]              status,
    output logic [ADDR_W-PG_SHIFT-1:0] rpn,
    output logic [2:0]              rights,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic                    mem_ready,
    input  logic [31:0]             mem_rdata
);
    localparam int ENT_SHIFT = 3;
    localparam int SLOT_W    = $clog2(GROUP_N);
    localparam int GRP_SHIFT = SLOT_W + ENT_SHIFT;
    localparam int API_W     = 30 - VSID_W;
    localparam int RPN_W     = ADDR_W - PG_SHIFT;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_N - 1);

    walk_e             state_q;
    logic [VSID_W-1:0] vsid_q;
    logic [PIDX_W-1:0] pidx_q;
    logic              key_q, nx_q, pass_q;
    logic [1:0]        acc_q;
    logic [SLOT_W-1:0] slot_q;
    logic [31:0]       wb_q;
    logic              done_q;
    logic [1:0]        status_q;
    logic [RPN_W-1:0]  rpn_q;
    logic [2:0]        rights_q;

    logic [ADDR_W-1:0] grp_addr, ent_addr;
    logic              hi_match;
    logic [2:0]        ck_rights;
    logic              ck_allow, ck_chg, ck_wb;
    logic              xfer;

    hpt_group_addr #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .GRP_SHIFT(GRP_SHIFT)
    ) u_grp (
        .base(tbl_base), .mask(tbl_mask), .vsid(vsid_q), .pidx(pidx_q),
        .second(pass_q), .grp_addr(grp_addr)
    );

    hpt_access_check u_chk (
        .key(key_q), .nx(nx_q), .acc(acc_q), .pp(mem_rdata[1:0]),
        .ref_in(mem_rdata[LO_REF]), .chg_in(mem_rdata[LO_CHG]),
        .rights(ck_rights), .allow(ck_allow), .chg_out(ck_chg), .need_wb(ck_wb)
    );

    // Entry address and upper-word match against the latched request.
    always_comb begin
        ent_addr = grp_addr + ADDR_W'({slot_q, {ENT_SHIFT{1'b0}}});
        hi_match = mem_rdata[HI_VALID] && (mem_rdata[HI_HSEL] == pass_q) &&
                   (mem_rdata[30:7] == vsid_q) &&
                   (mem_rdata[5:0] == pidx_q[PIDX_W-1 -: API_W]);
    end

    // Drives the memory port from the walk state.
    always_comb begin
        mem_valid = (state_q != S_IDLE);
        mem_write = (state_q == S_WRBACK);
        mem_addr  = (state_q == S_RD_HI) ? ent_addr : ent_addr + ADDR_W'(4);
        mem_wdata = wb_q;
        xfer      = mem_valid && mem_ready;
    end

    // Walk sequencer: request capture, scan, lower read, write-back, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            vsid_q   <= '0;
            pidx_q   <= '0;
            key_q    <= 1'b0;
            nx_q     <= 1'b0;
            acc_q    <= 2'd0;
            pass_q   <= 1'b0;
            slot_q   <= '0;
            wb_q     <= '0;
            done_q   <= 1'b0;
            status_q <= ST_HIT;
            rpn_q    <= '0;
            rights_q <= 3'b000;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        vsid_q  <= req_vsid;
                        pidx_q  <= req_pidx;
                        key_q   <= req_key;
                        nx_q    <= req_nx;
                        acc_q   <= req_acc;
                        pass_q  <= 1'b0;
                        slot_q  <= '0;
                        state_q <= S_RD_HI;
                    end
                end
                S_RD_HI: begin
                    if (xfer) begin
                        if (hi_match) begin
                            state_q <= S_RD_LO;
                        end else if (slot_q != LAST_SLOT) begin
                            slot_q <= slot_q + 1'b1;
                        end else if (!pass_q) begin
                            pass_q <= 1'b1;
                            slot_q <= '0;
                        end else begin
                            status_q <= ST_MISS;
                            rights_q <= 3'b000;
                            rpn_q    <= '0;
                            done_q   <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                    end
                end
                S_RD_LO: begin
                    if (xfer) begin
                        rpn_q    <= mem_rdata[31 -: RPN_W];
                        rights_q <= ck_rights;
                        status_q <= ck_allow ? ST_HIT : ST_DENY;
                        wb_q     <= {mem_rdata[31:LO_REF+1], 1'b1, ck_chg, mem_rdata[LO_CHG-1:0]};
                        if (ck_wb) begin
                            state_q <= S_WRBACK;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_WRBACK: begin
                    if (xfer) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != S_IDLE);
    assign done   = done_q;
    assign status = status_q;
    assign rpn    = rpn_q;
    assign rights = rights_q;

    // R9: a pending memory request holds its address and direction.
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R10: completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion is reported with the walker idle.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: every written-back lower word carries the referenced flag.
    assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> mem_wdata[LO_REF]);

    // R3: a miss grants no rights.
    assert_miss_norights_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_MISS) |-> (rights == 3'b000));

    // R8: a write-back is only ever issued to a lower word (+4 within the entry).
    assert_wb_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> (mem_addr[2:0] == 3'd4));
endmodule

// File: tb/hpt_walker_tb.sv
// Self-checking bench: swept protection/flag cases plus directed scan cases.
module hpt_walker_tb;
    localparam logic [31:0] BASE = 32'h0000_2000;
    localparam logic [31:0] MASK = 32'h0000_1FC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_vsid = '0;
    logic [15:0] req_pidx = '0;
    logic        req_key = 1'b0, req_nx = 1'b0;
    logic [1:0]  req_acc = 2'd0;
    logic        busy, done;
    logic [1:0]  status;
    logic [19:0] rpn;
    logic [2:0]  rights;
    logic        mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:4095];
    logic [7:0]  lfsr = 8'hA5;
    int nwr, nrd, ndone, tests, fails;
    logic [31:0] first_addr;
    bit watchdog_hit = 0;

    always #2 clk = ~clk;

    hpt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vsid(req_vsid),
        .req_pidx(req_pidx), .req_key(req_key), .req_nx(req_nx), .req_acc(req_acc),
        .tbl_base(BASE), .tbl_mask(MASK), .busy(busy), .done(done),
        .status(status), .rpn(rpn), .rights(rights), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    assign mem_ready = lfsr[1] | lfsr[4];
    assign mem_rdata = mem[mem_addr[13:2]];

    // Memory model, stall pattern and traffic counters.
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (done) ndone = ndone + 1;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr[13:2]] = mem_wdata;
                nwr = nwr + 1;
            end else begin
                if (nrd == 0) first_addr = mem_addr;
                nrd = nrd + 1;
            end
        end
    end

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog expired");
        fails = fails + 1;
        watchdog_hit = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] gaddr(input logic [23:0] v, input logic [15:0] p, input bit sec);
        logic [31:0] h;
        h = {8'h0, v} ^ {16'h0, p};
        if (sec) h = ~h;
        return BASE + ((h << 6) & MASK);
    endfunction

    function automatic logic [31:0] mk_hi(input logic [23:0] v, input logic [15:0] p, input bit h);
        return {1'b1, v, h, p[15:10]};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [19:0] r, input bit rf, input bit c, input logic [1:0] pp);
        return {r, 3'b000, rf, c, 5'b00000, pp};
    endfunction

    task automatic clr_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] hi, input logic [31:0] lo);
        mem[a[13:2]] = hi;
        mem[a[13:2] + 1] = lo;
    endtask

    task automatic run(input logic [23:0] v, input logic [15:0] p, input bit k, input bit x, input logic [1:0] a);
        int cyc;
        @(negedge clk);
        nwr = 0; nrd = 0; ndone = 0;
        req_vsid = v; req_pidx = p; req_key = k; req_nx = x; req_acc = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 2000) chk(1'b0, "R10 walk hung", 32'(cyc), 32'd0);
    endtask

    initial begin
        tests = 0; fails = 0; nwr = 0; nrd = 0; ndone = 0; first_addr = '0;
        clr_mem();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_valid, "R10 reset idle", {busy, done, mem_valid}, 0);
        rst_n = 1'b1;

        // Sweep: key, protection code, no-execute, access, starting flags.
        begin
            int it;
            it = 0;
            for (int k = 0; k < 2; k++)
            for (int pp = 0; pp < 4; pp++)
            for (int nx = 0; nx < 2; nx++)
            for (int ac = 0; ac < 3; ac++)
            for (int rc = 0; rc < 4; rc++) begin
                logic [23:0] v; logic [15:0] p; bit sec; int slot;
                bit r0, c0, rd, wr, ex, ok, nc; logic [31:0] la, lo_exp;
                logic [19:0] rp;
                v = 24'h3A5000 + 24'(it * 4099); p = 16'(it * 16'h0123 + 16'h0400);
                sec = it[0]; slot = it % 8; rp = 20'(it * 20'h00357 + 1);
                r0 = rc[1]; c0 = rc[0];
                clr_mem();
                if (sec) put(gaddr(v, p, 0) + 8 * 3, mk_hi(v, p, 1'b0) & 32'h7FFF_FFFF, 32'hFFFF_FFFF);
                la = gaddr(v, p, sec) + 32'(8 * slot);
                put(la, mk_hi(v, p, sec), mk_lo(rp, r0, c0, 2'(pp)));
                run(v, p, k[0], nx[0], 2'(ac));
                if (k == 0) begin rd = 1; wr = (pp != 3); end
                else begin rd = (pp != 0); wr = (pp == 2); end
                ex = !nx[0];
                ok = (ac == 1) ? wr : (ac == 2) ? ex : rd;
                nc = c0 | ((ac == 1) && ok);
                lo_exp = mk_lo(rp, 1'b1, nc, 2'(pp));
                chk(status == (ok ? 2'd0 : 2'd2), "R6 status", 32'(status), ok ? 0 : 2);
                chk(rights == {rd, wr & nc, ex}, k == 0 ? "R4 rights key0" : "R5 rights key1",
                    32'(rights), 32'({rd, wr & nc, ex}));
                chk(rpn == rp, "R10 rpn", 32'(rpn), 32'(rp));
                chk(mem[la[13:2] + 1] == lo_exp, "R7 flags", mem[la[13:2] + 1], lo_exp);
                chk(nwr == ((!r0 || (nc && !c0)) ? 1 : 0), "R8 writeback count", 32'(nwr),
                    (!r0 || (nc && !c0)) ? 1 : 0);
                chk(nrd == (sec ? 8 : 0) + slot + 2, sec ? "R3 read count" : "R2 read count",
                    32'(nrd), 32'((sec ? 8 : 0) + slot + 2));
                chk(first_addr == gaddr(v, p, 0), "R1 first address", first_addr, gaddr(v, p, 0));
                it++;
            end
        end

        // R3: decoys in both groups, none matching.
        begin
            logic [23:0] v; logic [15:0] p;
            v = 24'h00C0DE; p = 16'hBEEF;
            clr_mem();
            put(gaddr(v, p, 0), mk_hi(v, p, 1'b1), mk_lo(20'h11111, 0, 0, 0));
            put(gaddr(v, p, 0) + 8, mk_hi(v ^ 24'h1, p, 1'b0), mk_lo(20'h22222, 0, 0, 0));
            put(gaddr(v, p, 1), mk_hi(v, p, 1'b0), mk_lo(20'h33333, 0, 0, 0));
            put(gaddr(v, p, 1) + 16, mk_hi(v, p ^ 16'h0400, 1'b1), mk_lo(20'h44444, 0, 0, 0));
            put(gaddr(v, p, 1) + 24, mk_hi(v, p, 1'b1) & 32'h7FFF_FFFF, mk_lo(20'h55555, 0, 0, 0));
            run(v, p, 1'b0, 1'b0, 2'd0);
            chk(status == 2'd1, "R3 miss status", 32'(status), 1);
            chk(rights == 3'b000, "R3 miss rights", 32'(rights), 0);
            chk(nwr == 0, "R3 miss no write", 32'(nwr), 0);
            chk(nrd == 16, "R3 miss reads both groups", 32'(nrd), 16);
        end

        // R2: first match wins; R10: request during walk ignored.
        begin
            logic [23:0] v; logic [15:0] p; logic [31:0] g;
            v = 24'h777777; p = 16'h1234; g = gaddr(v, p, 0);
            clr_mem();
            put(g + 16, mk_hi(v, p, 1'b0), mk_lo(20'hAAAAA, 1, 1, 2'd2));
            put(g + 40, mk_hi(v, p, 1'b0), mk_lo(20'hBBBBB, 1, 1, 2'd2));
            @(negedge clk);
            nwr = 0; nrd = 0; ndone = 0;
            req_vsid = v; req_pidx = p; req_key = 0; req_nx = 0; req_acc = 2'd0;
            req_valid = 1'b1;
            @(negedge clk);
            req_vsid = 24'h123456; req_acc = 2'd1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
            chk(rpn == 20'hAAAAA, "R2 first match", 32'(rpn), 32'hAAAAA);
            chk(nrd == 4, "R2 stop at first match", 32'(nrd), 4);
            chk(status == 2'd0 && nwr == 0, "R10 mid-walk request ignored", {status, 8'(nwr)}, 0);
            repeat (40) @(negedge clk);
            chk(ndone == 1, "R10 single done", 32'(ndone), 1);
        end

        if (!watchdog_hit) begin
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule